// File: doc/BRIEF.md
# Microcoded Variable-Length Control Sequencer

This block is the control unit of a small CPU whose registers, memory and ALU share one 8-bit bus. It holds the instruction register and a micro-step counter. On every step it issues a control word of strobes: which unit drives the bus, which units load from it, program counter increment or load, stack pointer count, memory write, and ALU mode. The control word comes from a combinational table addressed by the opcode class, the current step and the carry and zero flags. The flags are part of the address so that conditional jumps take a different path.

Every instruction begins with the same two fetch steps. Two-byte instructions then spend extra steps fetching their argument byte. As soon as an instruction's final step is done, the step counter goes back to zero, so short instructions do not wait out the six-step maximum. During the second fetch step the table decodes the opcode byte that is on the memory bus at that moment. This lets a one-byte instruction end right at that step. A halt instruction freezes the counter until reset. The data path, the memory and the program counter are outside the block.

Top module: `mseq_top`

## Requirements
- R1: A synchronous reset puts the step counter at 0 and the instruction register at 0x00. After reset, the control word is the step-0 word: bits 0 and 6 set and all other bits clear.
- R2: Control word bits are as follows.
  - Bus drivers: 0 PC, 1 memory, 2 register file, 3 ALU, 4 stack pointer, 5 argument latch.
  - Loads: 6 address register, 7 instruction register, 8 argument latch, 11 register file, 12 ALU operand B.
  - Program counter: 9 increment, 10 load.
  - ALU and flags: 13 ALU subtract, 14 flag load.
  - Stack pointer: 15 increment, 16 decrement.
  - Other: 17 memory write, 18 halt, 19 source select, 20 final step.

  Step 0 always sets bits 0 and 6. Step 1 always sets bits 1, 7 and 9, and the instruction register captures the memory byte at the end of step 1.
- R3: The counter advances by one each cycle. It returns to 0 right after an instruction's final step. Instruction lengths in steps:
  - 2: 0x00 no-op.
  - 4: 0x10-0x13 load immediate into register op[1:0]; 0x40-0x4F subtract; 0x50-0x5F add (destination op[3:2], source op[1:0]); 0x70-0x7F load register op[3:2] from address in register op[1:0]; 0x90-0x9F store register op[1:0] to address in register op[3:2]; 0xB4-0xB7 pop; 0x80 absolute jump.
  - 5: 0xB0-0xB3 push.
  - 6: 0x60-0x63 load from direct address.
- R4: No instruction takes more than six steps, fetch included. The counter never passes step 5.
- R5: Two-byte instructions (0x10-0x13, 0x60-0x63, jumps) fetch their argument in a step that sets argument load (8) together with PC increment (9). A taken jump sets PC load (10) in that step instead of PC increment.
- R6: 0x81 jumps on carry and 0x82 jumps on zero. When the flag is 1, the jump takes 4 steps and its final step sets PC load (10). When the flag is 0, the jump takes 3 steps, and its final step sets PC increment (9) but not PC load.
- R7: 0x01 halts. At step 2, bit 18 becomes set and the step counter stays at 2 until reset.
- R8: At most one bus-driver bit (bits 0 to 5) is set in any step.
- R9: reg_sel_o gives opcode bits [1:0] when bit 19 is set and opcode bits [3:2] otherwise. Register writes of subtract, add and register-indirect load target op[3:2]. Writes of load-immediate, direct load and pop target op[1:0].
- R10: Opcodes not listed in R3, R6 or R7 behave as a 2-step no-op.
- R11: The final step of subtract sets ALU subtract (13), flag load (14) and register load (11). The final step of add sets 14 and 11 but not 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_data | input | DATA_W | Byte read from memory, captured as opcode in step 1 |
| cf | input | 1 | ALU carry flag |
| zf | input | 1 | ALU zero flag |
| ctrl_o | output | 21 | Control word, bit layout in R2 |
| step_o | output | STEP_W | Current micro-step |
| reg_sel_o | output | 2 | Register-file select for this step |
| opcode_o | output | DATA_W | Instruction register contents |

## Verification
The assertions assume that the flags hold steady from the first decision step of a conditional jump to its end. They also assume that mem_data holds the intended opcode during step 1. The data path guarantees both, because flags only change on a flag-load strobe. The bench holds mem_data and both flags fixed for the whole length of each instruction. It draws a new opcode and new flags only when the step counter is back at 0. Random opcodes exclude halt, which is exercised in a directed case that ends in reset.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   localparam int CW = 21;

   // bus drivers, one-hot
   localparam int C_PC_OUT   = 0;
   localparam int C_MEM_OUT  = 1;
   localparam int C_REG_OUT  = 2;
   localparam int C_ALU_OUT  = 3;
   localparam int C_SP_OUT   = 4;
   localparam int C_ARG_OUT  = 5;
   localparam int N_DRIVERS  = 6;
   // loads and strobes
   localparam int C_MAR_LD   = 6;
   localparam int C_IR_LD    = 7;
   localparam int C_ARG_LD   = 8;
   localparam int C_PC_INC   = 9;
   localparam int C_PC_LD    = 10;
   localparam int C_REG_LD   = 11;
   localparam int C_ALUB_LD  = 12;
   localparam int C_ALU_SUB  = 13;
   localparam int C_FLAG_LD  = 14;
   localparam int C_SP_INC   = 15;
   localparam int C_SP_DEC   = 16;
   localparam int C_MEM_WR   = 17;
   localparam int C_HALT     = 18;
   localparam int C_SEL_SRC  = 19;
   localparam int C_LAST     = 20;

   typedef enum logic [3:0] {
      K_NOP, K_HLT, K_MVI, K_SUB, K_ADD, K_LDA, K_LDI,
      K_JMP, K_JC, K_JZ, K_ST, K_PUSH, K_POP
   } iclass_t;

   function automatic logic [CW-1:0] bm(input int idx);
      return CW'(1) << idx;
   endfunction

endpackage

// File: rtl/mseq_decode.sv
module mseq_decode
   import mseq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] op,
   output iclass_t           cls
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("mseq_decode: opcode table is laid out for 8-bit opcodes");
      end
   endgenerate

   always_comb begin
      casez (op)
         8'h01:        cls = K_HLT;
         8'b0001_00??: cls = K_MVI;
         8'b0100_????: cls = K_SUB;
         8'b0101_????: cls = K_ADD;
         8'b0110_00??: cls = K_LDA;
         8'b0111_????: cls = K_LDI;
         8'h80:        cls = K_JMP;
         8'h81:        cls = K_JC;
         8'h82:        cls = K_JZ;
         8'b1001_????: cls = K_ST;
         8'b1011_00??: cls = K_PUSH;
         8'b1011_01??: cls = K_POP;
         default:      cls = K_NOP;
      endcase
   end

endmodule

// File: rtl/mseq_uword.sv
module mseq_uword
   import mseq_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  iclass_t          cls,
   input  logic [STEP_W-1:0] step,
   input  logic             cf,
   input  logic             zf,
   output logic [CW-1:0]    cw
);

   logic [31:0] st_i;
   logic        taken;

   assign st_i  = 32'(step);
   assign taken = (cls == K_JMP) || (cls == K_JC && cf) || (cls == K_JZ && zf);

   always_comb begin
      cw = bm(C_LAST);
      case (st_i)
         32'd0: cw = bm(C_PC_OUT) | bm(C_MAR_LD);
         32'd1: cw = bm(C_MEM_OUT) | bm(C_IR_LD) | bm(C_PC_INC)
                   | ((cls == K_NOP) ? bm(C_LAST) : '0);
         32'd2: begin
            case (cls)
               K_HLT:        cw = bm(C_HALT);
               K_MVI, K_LDA: cw = bm(C_PC_OUT) | bm(C_MAR_LD);
               K_SUB, K_ADD: cw = bm(C_REG_OUT) | bm(C_SEL_SRC) | bm(C_ALUB_LD);
               K_LDI:        cw = bm(C_REG_OUT) | bm(C_SEL_SRC) | bm(C_MAR_LD);
               K_JMP, K_JC, K_JZ:
                  cw = taken ? (bm(C_PC_OUT) | bm(C_MAR_LD))
                             : (bm(C_PC_INC) | bm(C_LAST));
               K_ST:         cw = bm(C_REG_OUT) | bm(C_MAR_LD);
               K_PUSH:       cw = bm(C_SP_DEC);
               K_POP:        cw = bm(C_SP_OUT) | bm(C_MAR_LD);
               default:      cw = bm(C_LAST);
            endcase
         end
         32'd3: begin
            case (cls)
               K_HLT: cw = bm(C_HALT);
               K_MVI: cw = bm(C_MEM_OUT) | bm(C_ARG_LD) | bm(C_PC_INC)
                         | bm(C_REG_LD) | bm(C_SEL_SRC) | bm(C_LAST);
               K_LDA: cw = bm(C_MEM_OUT) | bm(C_ARG_LD) | bm(C_PC_INC);
               K_SUB: cw = bm(C_ALU_OUT) | bm(C_ALU_SUB) | bm(C_FLAG_LD)
                         | bm(C_REG_LD) | bm(C_LAST);
               K_ADD: cw = bm(C_ALU_OUT) | bm(C_FLAG_LD) | bm(C_REG_LD) | bm(C_LAST);
               K_LDI: cw = bm(C_MEM_OUT) | bm(C_REG_LD) | bm(C_LAST);
               K_JMP, K_JC, K_JZ:
                  cw = bm(C_MEM_OUT) | bm(C_ARG_LD) | bm(C_PC_LD) | bm(C_LAST);
               K_ST:  cw = bm(C_REG_OUT) | bm(C_SEL_SRC) | bm(C_MEM_WR) | bm(C_LAST);
               K_PUSH: cw = bm(C_SP_OUT) | bm(C_MAR_LD);
               K_POP: cw = bm(C_MEM_OUT) | bm(C_REG_LD) | bm(C_SEL_SRC)
                         | bm(C_SP_INC) | bm(C_LAST);
               default: cw = bm(C_LAST);
            endcase
         end
         32'd4: begin
            case (cls)
               K_LDA:  cw = bm(C_ARG_OUT) | bm(C_MAR_LD);
               K_PUSH: cw = bm(C_REG_OUT) | bm(C_SEL_SRC) | bm(C_MEM_WR) | bm(C_LAST);
               default: cw = bm(C_LAST);
            endcase
         end
         32'd5: begin
            case (cls)
               K_LDA:  cw = bm(C_MEM_OUT) | bm(C_REG_LD) | bm(C_SEL_SRC) | bm(C_LAST);
               default: cw = bm(C_LAST);
            endcase
         end
         default: cw = bm(C_LAST);
      endcase
   end

endmodule

// File: rtl/mseq_stepper.sv
module mseq_stepper #(
   parameter int MAX_STEPS = 6,
   parameter int STEP_W    = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              last,
   input  logic              halt,
   output logic [STEP_W-1:0] step
);

   localparam logic [STEP_W-1:0] TOP = STEP_W'(MAX_STEPS - 1);

   logic              wrap;
   logic [STEP_W-1:0] step_nx;

   generate
      if ((2 ** STEP_W) == MAX_STEPS) begin : g_natural_wrap
         assign wrap = last;
      end else begin : g_cap_wrap
         assign wrap = last || (step == TOP);
      end
   endgenerate

   always_comb begin
      if (halt)      step_nx = step;
      else if (wrap) step_nx = '0;
      else           step_nx = step + STEP_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) step <= '0;
      else     step <= step_nx;
   end

   p_step_cap_r4: assert property (@(posedge clk) disable iff (rst)
      step <= TOP);

   p_restart_r3: assert property (@(posedge clk) disable iff (rst)
      (last && !halt) |=> step == '0);

   p_advance_r3: assert property (@(posedge clk) disable iff (rst)
      (!last && !halt && step != TOP) |=> step == $past(step) + STEP_W'(1));

   p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
      halt |=> $stable(step));

endmodule

// File: rtl/mseq_top.sv
module mseq_top
   import mseq_pkg::*;
#(
   parameter  int DATA_W    = 8,
   parameter  int MAX_STEPS = 6,
   localparam int STEP_W    = $clog2(MAX_STEPS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] mem_data,
   input  logic              cf,
   input  logic              zf,
   output logic [CW-1:0]     ctrl_o,
   output logic [STEP_W-1:0] step_o,
   output logic [1:0]        reg_sel_o,
   output logic [DATA_W-1:0] opcode_o
);

   generate
      if (MAX_STEPS < 6) begin : g_bad_steps
         $error("mseq_top: microprogram needs six steps");
      end
      if (DATA_W != 8) begin : g_bad_data
         $error("mseq_top: data width must be 8");
      end
   endgenerate

   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] op_eff;
   logic [STEP_W-1:0] step;
   logic [CW-1:0]     cw;
   iclass_t           cls;

   // during the opcode fetch step, decode the byte on the bus directly
   assign op_eff = (step == STEP_W'(1)) ? mem_data : ir;

   mseq_decode #(.DATA_W(DATA_W)) u_dec (
      .op  (op_eff),
      .cls (cls)
   );

   mseq_uword #(.STEP_W(STEP_W)) u_rom (
      .cls  (cls),
      .step (step),
      .cf   (cf),
      .zf   (zf),
      .cw   (cw)
   );

   mseq_stepper #(.MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)) u_step (
      .clk  (clk),
      .rst  (rst),
      .last (cw[C_LAST]),
      .halt (cw[C_HALT]),
      .step (step)
   );

   always_ff @(posedge clk) begin
      if (rst)              ir <= '0;
      else if (cw[C_IR_LD]) ir <= mem_data;
   end

   assign ctrl_o    = cw;
   assign step_o    = step;
   assign opcode_o  = ir;
   assign reg_sel_o = cw[C_SEL_SRC] ? op_eff[1:0] : op_eff[3:2];

   p_one_driver_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cw[N_DRIVERS-1:0]));

   p_irld_fetch_r2: assert property (@(posedge clk) disable iff (rst)
      cw[C_IR_LD] |-> step == STEP_W'(1));

   p_ir_capture_r2: assert property (@(posedge clk) disable iff (rst)
      cw[C_IR_LD] |=> ir == $past(mem_data));

   p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !cw[C_IR_LD] |=> $stable(ir));

   p_pc_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
      !(cw[C_PC_INC] && cw[C_PC_LD]));

endmodule

// File: tb/mseq_top_bench.sv
module mseq_top_bench;

   localparam int B_PC_OUT = 0, B_MEM_OUT = 1, B_MAR_LD = 6, B_IR_LD = 7;
   localparam int B_ARG_LD = 8, B_PC_INC = 9, B_PC_LD = 10, B_REG_LD = 11;
   localparam int B_ALU_SUB = 13, B_FLAG_LD = 14, B_HALT = 18;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  mem_data = 8'h00;
   logic        cf = 1'b0, zf = 1'b0;
   logic [20:0] ctrl_o;
   logic [2:0]  step_o;
   logic [1:0]  reg_sel_o;
   logic [7:0]  opcode_o;

   int n_chk = 0, n_fail = 0, ntr = 0;
   bit done = 1'b0;
   logic [20:0] tr [0:7];
   logic [1:0]  sl [0:7];

   always #2 clk = ~clk;

   mseq_top u_mseq_top (
      .clk(clk), .rst(rst), .mem_data(mem_data), .cf(cf), .zf(zf),
      .ctrl_o(ctrl_o), .step_o(step_o), .reg_sel_o(reg_sel_o), .opcode_o(opcode_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [7:0] op, input logic c, input logic z);
      if (op == 8'h00) return 2;
      if (op[7:2] == 6'b000100) return 4;
      if (op[7:4] == 4'h4 || op[7:4] == 4'h5 || op[7:4] == 4'h7 || op[7:4] == 4'h9) return 4;
      if (op[7:2] == 6'b011000) return 6;
      if (op == 8'h80) return 4;
      if (op == 8'h81) return c ? 4 : 3;
      if (op == 8'h82) return z ? 4 : 3;
      if (op[7:2] == 6'b101100) return 5;
      if (op[7:2] == 6'b101101) return 4;
      return 2;
   endfunction

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
   endtask

   task automatic run_instr(input logic [7:0] op, input logic c, input logic z);
      mem_data = op; cf = c; zf = z;
      #1;
      ntr = 0;
      do begin
         tr[ntr] = ctrl_o;
         sl[ntr] = reg_sel_o;
         ntr++;
         @(negedge clk);
         #1;
      end while (step_o != 3'd0 && ntr < 8);
   endtask

   task automatic check_instr(input logic [7:0] op, input logic c, input logic z);
      int el;
      int drv_bad;
      logic [20:0] lw;
      el = exp_len(op, c, z);
      run_instr(op, c, z);
      // R3 R4 R10: length from opcode and flags
      chk(ntr == el, "R3/R4/R10 length", 32'(ntr), 32'(el));
      chk(tr[0] == 21'((1 << B_PC_OUT) | (1 << B_MAR_LD)), "R2 step0 word",
          32'(tr[0]), 32'h41);
      chk(tr[1][B_MEM_OUT] && tr[1][B_IR_LD] && tr[1][B_PC_INC], "R2 step1 word",
          32'(tr[1]), 32'h282);
      chk(opcode_o == op, "R2 opcode captured", 32'(opcode_o), 32'(op));
      drv_bad = 0;
      for (int k = 0; k < ntr && k < 8; k++)
         if ($countones(tr[k][5:0]) > 1) drv_bad++;
      chk(drv_bad == 0, "R8 single driver", 32'(drv_bad), 0);
      if (ntr == el && el >= 3) begin
         lw = tr[el-1];
         if (op[7:2] == 6'b000100 || op[7:2] == 6'b011000) begin
            chk(tr[3][B_ARG_LD] && tr[3][B_PC_INC], "R5 argument step", 32'(tr[3]), 32'h300);
            chk(lw[B_REG_LD] && sl[el-1] == op[1:0], "R9 target op[1:0]",
                32'(sl[el-1]), 32'(op[1:0]));
         end
         if (op[7:4] == 4'h4 || op[7:4] == 4'h5) begin
            chk(lw[B_ALU_SUB] == (op[7:4] == 4'h4) && lw[B_FLAG_LD] && lw[B_REG_LD],
                "R11 alu final step", 32'(lw), 32'(op[7:4]));
            chk(sl[el-1] == op[3:2], "R9 target op[3:2]", 32'(sl[el-1]), 32'(op[3:2]));
         end
         if (op[7:4] == 4'h7)
            chk(sl[el-1] == op[3:2], "R9 indirect load target", 32'(sl[el-1]), 32'(op[3:2]));
         if (op[7:2] == 6'b101101)
            chk(sl[el-1] == op[1:0], "R9 pop target", 32'(sl[el-1]), 32'(op[1:0]));
         if (op == 8'h80 || op == 8'h81 || op == 8'h82) begin
            if (el == 4)
               chk(lw[B_PC_LD] && lw[B_ARG_LD] && !lw[B_PC_INC], "R6/R5 jump taken",
                   32'(lw), 32'h500);
            else
               chk(lw[B_PC_INC] && !lw[B_PC_LD], "R6 jump not taken", 32'(lw), 32'h200);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] rop;
      logic       rc, rz;
      void'($urandom(32'd4711));
      do_reset();
      // R1 reset state
      chk(step_o == 3'd0, "R1 step after reset", 32'(step_o), 0);
      chk(opcode_o == 8'h00, "R1 ir after reset", 32'(opcode_o), 0);
      chk(ctrl_o == 21'h41, "R1 ctrl after reset", 32'(ctrl_o), 32'h41);

      // directed corner cases
      check_instr(8'h00, 0, 0);
      check_instr(8'h05, 0, 0);   // R10 unknown
      check_instr(8'h64, 0, 0);   // R10 unknown next to direct load
      check_instr(8'hFF, 1, 1);   // R10 unknown
      check_instr(8'h12, 0, 0);
      check_instr(8'h4B, 0, 0);
      check_instr(8'h56, 0, 0);
      check_instr(8'h63, 0, 0);   // R4 six steps
      check_instr(8'h79, 0, 0);
      check_instr(8'h80, 0, 0);
      check_instr(8'h81, 1, 0);
      check_instr(8'h81, 0, 1);
      check_instr(8'h82, 0, 1);
      check_instr(8'h82, 1, 0);
      check_instr(8'h97, 0, 0);
      check_instr(8'hB2, 0, 0);
      check_instr(8'hB5, 0, 0);

      // constrained random stream, halt excluded
      for (int i = 0; i < 300; i++) begin
         rop = 8'($urandom);
         if (rop == 8'h01) rop = 8'h81;
         rc = 1'($urandom);
         rz = 1'($urandom);
         check_instr(rop, rc, rz);
      end

      // R7 halt
      run_instr(8'h01, 0, 0);
      chk(step_o == 3'd2, "R7 halted step", 32'(step_o), 2);
      chk(ctrl_o[B_HALT], "R7 halt bit", 32'(ctrl_o), 32'h40000);
      repeat (3) @(negedge clk);
      chk(step_o == 3'd2 && ctrl_o[B_HALT], "R7 halt holds", 32'(step_o), 2);
      do_reset();
      chk(step_o == 3'd0 && ctrl_o == 21'h41, "R1 reset leaves halt", 32'(step_o), 0);

      // R1 reset in the middle of a direct load
      mem_data = 8'h61;
      repeat (3) @(negedge clk);
      chk(step_o == 3'd3, "R3 mid-instruction step", 32'(step_o), 3);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(step_o == 3'd0, "R1 mid reset step", 32'(step_o), 0);
      chk(opcode_o == 8'h00, "R1 mid reset ir", 32'(opcode_o), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule